// File: doc/BRIEF.md
# Command-Parameter Memory Bank Controller

This block sits on an 8-bit CPU bus with a 16-bit address. It turns CPU and pattern-fetch addresses into wider physical addresses for external ROM and RAM. Software configures it indirectly in two steps. A write to the lower command range picks one of sixteen internal functions. A write to the parameter range then gives that function its value.

The functions cover eight 1 KB pattern windows and four 8 KB program windows. One of the program windows, at 0x6000–0x7FFF, can map to either RAM or ROM. The others serve 0x8000–0xFFFF, and the top 8 KB window there is tied to the last ROM bank. The functions also set the 2-bit nametable mirroring mode. The last three functions are not stored here. They are handed on to a companion interval timer as a one-cycle strobe with a selector and a data byte.

The block translates addresses combinationally. Configuration writes are registered and take effect on the clock edge that ends the write cycle.

Top module: `bank_cmd_ctrl`

## Requirements
- R1: A CPU write with address 0x8000–0x9FFF loads the 4-bit command register with data bits 3:0. Data bits 7:4 are discarded.
- R2: A parameter write (address 0xA000–0xBFFF) while command 0–7 is selected stores the data byte as the bank of pattern window N = command. A pattern address A (13 bits) then translates to `{bank[A[12:10]], A[9:0]}`.
- R3: A parameter write under command 8 sets the 0x6000 window. Data bit 7 = 1 maps it to RAM (`prg_is_ram` = 1, `ram_en` = 1). Bit 7 = 0 maps it to ROM. Bits 5:0 are its bank, and the translated address is `{bank, A[12:0]}`.
- R4: Parameter writes under commands 9, 10 and 11 set the ROM bank of the windows at 0x8000, 0xA000 and 0xC000 respectively, from data bits 5:0. Bits 7:6 are ignored. Translation is `{bank, A[12:0]}`.
- R5: The window at 0xE000–0xFFFF always translates with bank = PRG_ROM_BANKS−1, including straight out of reset.
- R6: A parameter write under command 12 sets `mirror` to data bits 1:0. The codes are 0 vertical, 1 horizontal, 2 single-screen lower, 3 single-screen upper. Upper data bits are ignored.
- R7: A parameter write under commands 13, 14 or 15 pulses `irq_wr` in that same cycle. `irq_sel` is 0, 1 or 2 respectively (control, count low, count high), and `irq_data` is the data byte. No bank or mirroring state changes.
- R8: `ram_we` is 1 only for a CPU write to 0x6000–0x7FFF while the window is mapped to RAM. It stays 0 while the window is mapped to ROM.
- R9: After reset, the command register, all banks and `mirror` are 0, and RAM is disabled.
- R10: CPU writes outside 0x8000–0xBFFF (for example 0x4020, 0xC000 and 0x6000) change neither the command register nor any bank.
- R11: `prg_hit` is 1 only for CPU addresses 0x6000–0xFFFF. Otherwise `prg_hit` = 0 and `prg_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write cycle, one clock per write |
| ppu_addr | input | 13 | Pattern fetch address 0x0000–0x1FFF |
| chr_addr | output | CHR_BANK_W+10 | Translated pattern memory address |
| prg_addr | output | PRG_BANK_W+13 | Translated program memory address |
| prg_hit | output | 1 | CPU address falls in a mapped program window |
| prg_is_ram | output | 1 | Current CPU access targets RAM |
| ram_we | output | 1 | Write enable toward RAM |
| ram_en | output | 1 | 0x6000 window is mapped to RAM |
| mirror | output | 2 | Nametable mirroring mode |
| irq_wr | output | 1 | Strobe toward the interval timer |
| irq_sel | output | 2 | Timer field: 0 control, 1 count low, 2 count high |
| irq_data | output | 8 | Byte for the timer field |

## Verification
Two cases are hard to reach from the ports. The first is a stray write in the 0xC000 range whose data looks like a valid command. The bench sets command 9, writes to 0xC000 with data 0x0A, and then issues a parameter write. That write must still land on the 0x8000 window and not on 0xA000. The second is the timer hand-off, which lasts only one cycle. The bench therefore samples `irq_wr`, `irq_sel` and `irq_data` while the parameter write is still being driven, before the edge. After the edge it confirms that the banks and mirroring did not move.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  localparam logic [3:0] CMD_CHR_MAX  = 4'd7;
  localparam logic [3:0] CMD_WRAM     = 4'd8;
  localparam logic [3:0] CMD_PRG_LO   = 4'd9;
  localparam logic [3:0] CMD_PRG_HI   = 4'd11;
  localparam logic [3:0] CMD_MIRROR   = 4'd12;
  localparam logic [3:0] CMD_IRQ_LO   = 4'd13;

  localparam logic [2:0] SEG_CMD   = 3'b100;
  localparam logic [2:0] SEG_PARAM = 3'b101;
  localparam logic [2:0] SEG_WRAM  = 3'b011;

  function automatic logic [1:0] irq_field(input logic [3:0] cmd);
    return cmd[1:0] - 2'd1;
  endfunction

endpackage

// File: rtl/bcc_cmd_decode.sv
module bcc_cmd_decode
  import bcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] seg,
  input  logic [7:0] cpu_data,
  input  logic       cpu_wr,
  output logic [3:0] cmd,
  output logic       param_wr,
  output logic       irq_wr,
  output logic [1:0] irq_sel,
  output logic [7:0] irq_data
);

  logic cmd_wr;

  assign cmd_wr   = cpu_wr && (seg == SEG_CMD);
  assign param_wr = cpu_wr && (seg == SEG_PARAM);

  always_ff @(posedge clk) begin
    if (!rst_n)      cmd <= 4'd0;
    else if (cmd_wr) cmd <= cpu_data[3:0];
  end

  assign irq_wr   = param_wr && (cmd >= CMD_IRQ_LO);
  assign irq_sel  = irq_field(cmd);
  assign irq_data = cpu_data;

  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (cmd == $past(cpu_data[3:0]))); // R1

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(cmd)); // R10

endmodule

// File: rtl/bcc_bank_regs.sv
module bcc_bank_regs
  import bcc_pkg::*;
#(
  parameter int CHR_BANK_W = 8,
  parameter int PRG_BANK_W = 6,
  parameter int CHR_WINS   = 8,
  parameter int ROM_WINS   = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  param_wr,
  input  logic [3:0]                            cmd,
  input  logic [7:0]                            data,
  output logic [CHR_WINS-1:0][CHR_BANK_W-1:0]   chr_bank,
  output logic [ROM_WINS-1:0][PRG_BANK_W-1:0]   rom_bank,
  output logic [PRG_BANK_W-1:0]                 wram_bank,
  output logic                                  ram_en,
  output logic [1:0]                            mirror
);

  logic wr_wram, wr_mirror;
  assign wr_wram   = param_wr && (cmd == CMD_WRAM);
  assign wr_mirror = param_wr && (cmd == CMD_MIRROR);

  for (genvar i = 0; i < CHR_WINS; i++) begin : g_chr
    always_ff @(posedge clk) begin
      if (!rst_n)                                chr_bank[i] <= '0;
      else if (param_wr && (cmd == 4'(i)))       chr_bank[i] <= data[CHR_BANK_W-1:0];
    end
  end

  for (genvar j = 0; j < ROM_WINS; j++) begin : g_rom
    always_ff @(posedge clk) begin
      if (!rst_n)                                      rom_bank[j] <= '0;
      else if (param_wr && (cmd == CMD_PRG_LO + 4'(j))) rom_bank[j] <= data[PRG_BANK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wram_bank <= '0;
      ram_en    <= 1'b0;
      mirror    <= MIR_VERT;
    end else begin
      if (wr_wram) begin
        wram_bank <= data[PRG_BANK_W-1:0];
        ram_en    <= data[7];
      end
      if (wr_mirror) mirror <= data[1:0];
    end
  end

  AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mirror |=> $stable(mirror)); // R6

  AST_RAM_EN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_en) |-> $past(wr_wram && data[7])); // R3

  AST_ROM_HOLD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (param_wr && cmd > CMD_MIRROR) |=> $stable(rom_bank) && $stable(chr_bank)); // R7

endmodule

// File: rtl/bcc_xlate.sv
module bcc_xlate
  import bcc_pkg::*;
#(
  parameter int CHR_BANK_W    = 8,
  parameter int PRG_BANK_W    = 6,
  parameter int PRG_ROM_BANKS = 64,
  parameter int CHR_WINS      = 8,
  parameter int ROM_WINS      = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [15:0]                           cpu_addr,
  input  logic                                  cpu_wr,
  input  logic [12:0]                           ppu_addr,
  input  logic [CHR_WINS-1:0][CHR_BANK_W-1:0]   chr_bank,
  input  logic [ROM_WINS-1:0][PRG_BANK_W-1:0]   rom_bank,
  input  logic [PRG_BANK_W-1:0]                 wram_bank,
  input  logic                                  ram_en,
  output logic [CHR_BANK_W+9:0]                 chr_addr,
  output logic [PRG_BANK_W+12:0]                prg_addr,
  output logic                                  prg_hit,
  output logic                                  prg_is_ram,
  output logic                                  ram_we
);

  localparam int PRG_AW = PRG_BANK_W + 13;
  localparam logic [PRG_BANK_W-1:0] LAST_BANK = PRG_BANK_W'(PRG_ROM_BANKS - 1);

  function automatic logic [PRG_AW-1:0] join_prg(input logic [PRG_BANK_W-1:0] b,
                                                 input logic [12:0] off);
    return {b, off};
  endfunction

  function automatic logic [CHR_BANK_W+9:0] join_chr(input logic [CHR_BANK_W-1:0] b,
                                                     input logic [9:0] off);
    return {b, off};
  endfunction

  logic [3:0][PRG_BANK_W-1:0] slot_bank;
  for (genvar s = 0; s < 4; s++) begin : g_slot
    if (s < ROM_WINS) begin : g_sw
      assign slot_bank[s] = rom_bank[s];
    end else begin : g_fixed
      assign slot_bank[s] = LAST_BANK;
    end
  end

  logic                  in_wram;
  logic [PRG_BANK_W-1:0] sel_bank;

  assign in_wram = (cpu_addr[15:13] == SEG_WRAM);

  always_comb begin
    prg_hit    = 1'b0;
    prg_is_ram = 1'b0;
    sel_bank   = '0;
    if (cpu_addr[15]) begin
      prg_hit  = 1'b1;
      sel_bank = slot_bank[cpu_addr[14:13]];
    end else if (in_wram) begin
      prg_hit    = 1'b1;
      prg_is_ram = ram_en;
      sel_bank   = wram_bank;
    end
  end

  assign prg_addr = prg_hit ? join_prg(sel_bank, cpu_addr[12:0]) : '0;
  assign ram_we   = cpu_wr && in_wram && ram_en;
  assign chr_addr = join_chr(chr_bank[ppu_addr[12:10]], ppu_addr[9:0]);

  AST_RAM_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_en && prg_is_ram && prg_hit)); // R8

  AST_FIXED_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (prg_addr[PRG_AW-1:13] == LAST_BANK)); // R5

  AST_NO_HIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !prg_hit |-> (prg_addr == '0 && !ram_we)); // R11

endmodule

// File: rtl/bank_cmd_ctrl.sv
module bank_cmd_ctrl
  import bcc_pkg::*;
#(
  parameter int CHR_BANK_W    = 8,
  parameter int PRG_BANK_W    = 6,
  parameter int PRG_ROM_BANKS = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             cpu_addr,
  input  logic [7:0]              cpu_data,
  input  logic                    cpu_wr,
  input  logic [12:0]             ppu_addr,
  output logic [CHR_BANK_W+9:0]   chr_addr,
  output logic [PRG_BANK_W+12:0]  prg_addr,
  output logic                    prg_hit,
  output logic                    prg_is_ram,
  output logic                    ram_we,
  output logic                    ram_en,
  output logic [1:0]              mirror,
  output logic                    irq_wr,
  output logic [1:0]              irq_sel,
  output logic [7:0]              irq_data
);

  localparam int CHR_WINS = 8;
  localparam int ROM_WINS = 3;

  logic [3:0]                          cmd;
  logic                                param_wr;
  logic [CHR_WINS-1:0][CHR_BANK_W-1:0] chr_bank;
  logic [ROM_WINS-1:0][PRG_BANK_W-1:0] rom_bank;
  logic [PRG_BANK_W-1:0]               wram_bank;

  bcc_cmd_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .seg      (cpu_addr[15:13]),
    .cpu_data (cpu_data),
    .cpu_wr   (cpu_wr),
    .cmd      (cmd),
    .param_wr (param_wr),
    .irq_wr   (irq_wr),
    .irq_sel  (irq_sel),
    .irq_data (irq_data)
  );

  bcc_bank_regs #(
    .CHR_BANK_W (CHR_BANK_W),
    .PRG_BANK_W (PRG_BANK_W),
    .CHR_WINS   (CHR_WINS),
    .ROM_WINS   (ROM_WINS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .param_wr  (param_wr),
    .cmd       (cmd),
    .data      (cpu_data),
    .chr_bank  (chr_bank),
    .rom_bank  (rom_bank),
    .wram_bank (wram_bank),
    .ram_en    (ram_en),
    .mirror    (mirror)
  );

  bcc_xlate #(
    .CHR_BANK_W    (CHR_BANK_W),
    .PRG_BANK_W    (PRG_BANK_W),
    .PRG_ROM_BANKS (PRG_ROM_BANKS),
    .CHR_WINS      (CHR_WINS),
    .ROM_WINS      (ROM_WINS)
  ) u_xl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wr     (cpu_wr),
    .ppu_addr   (ppu_addr),
    .chr_bank   (chr_bank),
    .rom_bank   (rom_bank),
    .wram_bank  (wram_bank),
    .ram_en     (ram_en),
    .chr_addr   (chr_addr),
    .prg_addr   (prg_addr),
    .prg_hit    (prg_hit),
    .prg_is_ram (prg_is_ram),
    .ram_we     (ram_we)
  );

  AST_IRQ_NO_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wr |=> $stable(mirror) && $stable(ram_en)); // R7

endmodule

// File: tb/tb_bank_cmd_ctrl.sv
module tb_bank_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [12:0] ppu_addr = '0;
  logic [17:0] chr_addr;
  logic [18:0] prg_addr;
  logic        prg_hit, prg_is_ram, ram_we, ram_en, irq_wr;
  logic [1:0]  mirror, irq_sel;
  logic [7:0]  irq_data;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .chr_addr(chr_addr),
    .prg_addr(prg_addr), .prg_hit(prg_hit), .prg_is_ram(prg_is_ram),
    .ram_we(ram_we), .ram_en(ram_en), .mirror(mirror), .irq_wr(irq_wr),
    .irq_sel(irq_sel), .irq_data(irq_data)
  );

  // {cmd, data, pattern_probe, probe_addr, expected}
  localparam logic [47:0] VECS [7] = '{
    {4'd9,  8'h25, 1'b0, 16'h8123, 19'h4A123},
    {4'd10, 8'hC7, 1'b0, 16'hBFFF, 19'h0FFFF},
    {4'd11, 8'h3F, 1'b0, 16'hC000, 19'h7E000},
    {4'd8,  8'h83, 1'b0, 16'h6010, 19'h06010},
    {4'd0,  8'hAB, 1'b1, 16'h0005, 19'h2AC05},
    {4'd7,  8'h01, 1'b1, 16'h1FFF, 19'h007FF},
    {4'd3,  8'hFF, 1'b1, 16'h0C00, 19'h3FC00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic set_fn(input logic [3:0] c, input logic [7:0] d);
    bus_wr(16'h8000 | 16'(c), 8'h00 | 8'(c));
    bus_wr(16'hA000, d);
  endtask

  task automatic probe_cpu(input logic [15:0] a);
    cpu_addr = a; #2;
  endtask

  task automatic probe_ppu(input logic [12:0] a);
    ppu_addr = a; #2;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state, R5 fixed bank from reset
    probe_cpu(16'h8000);  chk("R9 rom bank0", 32'(prg_addr), 32'h0);
    probe_cpu(16'hE123);  chk("R5 fixed last after reset", 32'(prg_addr), 32'h7E123);
    probe_ppu(13'h1C00);  chk("R9 chr bank7", 32'(chr_addr), 32'h0);
    chk("R9 mirror", 32'(mirror), 32'h0);
    chk("R9 ram_en", 32'(ram_en), 32'h0);

    // vector table: R2 R3 R4
    foreach (VECS[i]) begin
      set_fn(VECS[i][47:44], VECS[i][43:36]);
      if (VECS[i][35]) begin
        probe_ppu(VECS[i][31:19]);
        chk("R2 pattern window", 32'(chr_addr), 32'(VECS[i][18:0]));
      end else begin
        probe_cpu(VECS[i][34:19]);
        chk("R4/R3 program window", 32'(prg_addr), 32'(VECS[i][18:0]));
      end
    end

    // R5 last bank unaffected by the switchable ones
    probe_cpu(16'hFFFF); chk("R5 fixed last", 32'(prg_addr), 32'h7FFFF);

    // R6 mirroring
    set_fn(4'd12, 8'hFD); chk("R6 mirror horizontal", 32'(mirror), 32'd1);
    bus_wr(16'hA000, 8'h02); chk("R6 mirror lower", 32'(mirror), 32'd2);
    bus_wr(16'hA000, 8'h07); chk("R6 mirror upper", 32'(mirror), 32'd3);
    bus_wr(16'hA000, 8'hF0); chk("R6 mirror vertical", 32'(mirror), 32'd0);

    // R7 timer hand-off
    for (int k = 13; k <= 15; k++) begin
      bus_wr(16'h9000, 8'(k));
      @(negedge clk);
      cpu_addr = 16'hB000; cpu_data = 8'h5A + 8'(k); cpu_wr = 1'b1; #2;
      chk("R7 irq_wr", 32'(irq_wr), 32'd1);
      chk("R7 irq_sel", 32'(irq_sel), 32'(k - 13));
      chk("R7 irq_data", 32'(irq_data), 32'(8'h5A + 8'(k)));
      @(negedge clk);
      cpu_wr = 1'b0;
    end
    probe_cpu(16'h8123); chk("R7 rom bank kept", 32'(prg_addr), 32'h4A123);
    chk("R7 mirror kept", 32'(mirror), 32'd0);
    chk("R7 ram_en kept", 32'(ram_en), 32'd1);

    // R8 / R3 RAM gating
    set_fn(4'd8, 8'h05);
    @(negedge clk);
    cpu_addr = 16'h6000; cpu_wr = 1'b1; #2;
    chk("R8 ram_we rom", 32'(ram_we), 32'd0);
    chk("R3 is_ram rom", 32'(prg_is_ram), 32'd0);
    chk("R3 rom bank5", 32'(prg_addr), 32'h0A000);
    @(negedge clk); cpu_wr = 1'b0;
    bus_wr(16'hA000, 8'h85);
    @(negedge clk);
    cpu_addr = 16'h7FFF; cpu_wr = 1'b1; #2;
    chk("R8 ram_we ram", 32'(ram_we), 32'd1);
    chk("R3 is_ram ram", 32'(prg_is_ram), 32'd1);
    @(negedge clk); cpu_wr = 1'b0;

    // R1 high nibble discarded, R10 stray writes
    bus_wr(16'h9FFF, 8'hF9);
    bus_wr(16'hC000, 8'h0A);
    bus_wr(16'h4020, 8'h0B);
    bus_wr(16'h6000, 8'h0A);
    bus_wr(16'hA000, 8'h11);
    probe_cpu(16'h8000); chk("R1 cmd low nibble", 32'(prg_addr), 32'h22000);
    probe_cpu(16'hA000); chk("R10 0xA000 bank kept", 32'(prg_addr), 32'h0E000);
    probe_cpu(16'hC000); chk("R10 0xC000 bank kept", 32'(prg_addr), 32'h7E000);

    // R11 unmapped range
    probe_cpu(16'h5000);
    chk("R11 hit", 32'(prg_hit), 32'd0);
    chk("R11 addr", 32'(prg_addr), 32'd0);
    probe_cpu(16'h6000); chk("R11 hit wram", 32'(prg_hit), 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule